// File: doc/BRIEF.md
# Time-Multiplexed Second-Order Recursive Filter

This block implements a two-pole, two-zero recursive filter on signed 16-bit samples. It does not build one multiplier for each coefficient. A small controller walks a fixed table of control steps, and each step binds the filter's operations onto a shared pool of multipliers and a single adder. Values that must survive from one step to the next are held in named registers. The coefficients are fixed-point constants set by parameters. The two delay states are updated once per accepted sample.

A producer places a sample on the input bus and raises a request line. The block captures the sample on the request's rising edge. It first shifts its delay line, then runs the scheduled operations and presents the result together with a ready flag. The ready flag stays up until the producer lowers its request. This closes a four-phase exchange. A parameter picks one or two multipliers, which trades latency for area without changing a single output bit.

Top module: `biquad_sched`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, out_rdy is 0 and out_sample is 0. The delay states start at zero, so the first result after reset depends only on the leading feed-forward term.
- R2: Each accepted sample first moves the state s1 into s2 and s0 into s1. It then computes s0 = x + kb1*s1 + kb2*s2 and out_sample = ka0*s0 + ka1*s1 + ka2*s2, bit-exact to the arithmetic of R3 and R4.
- R3: Coefficients are signed Q1.14 constants with defaults ka0 = ka2 = 4846, ka1 = 9627, kb1 = -3503 and kb2 = -7402. Each product is (c*s + 8192) shifted arithmetically right by 14. Examples: an input of 16384 after reset gives 4846, and an input of 2 after reset gives 1.
- R4: Every product and every sum is clamped to the range -32768..32767 rather than wrapping.
- R5: Count the edge at which the controller is idle and sees in_req high, with in_req low on the edge before, as edge 1. out_rdy goes high at edge 7 when NUM_MUL is 1 and at edge 6 when NUM_MUL is 2.
- R6: out_rdy stays high while in_req is high. It falls at the first edge that samples in_req low. If in_req was already low when the result arrives, out_rdy is high for exactly one cycle.
- R7: A rising in_req that arrives while a sample is being computed starts nothing. No second result appears, and a new sample needs a fresh rise after out_rdy has fallen.
- R8: out_sample changes only at the edge where out_rdy rises, and otherwise holds its value.
- R9: NUM_MUL = 2 produces the same out_sample values as NUM_MUL = 1 for the same input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_req | input | 1 | Sample request, four-phase |
| in_sample | input | 16 | Signed input sample, captured on the accepted request rise |
| out_rdy | output | 1 | Result ready, held until in_req falls |
| out_sample | output | 16 | Signed filtered sample |

## Verification
Two instances, one with one multiplier and one with two, receive identical stimulus, and both are compared against a bit-exact model. An impulse after reset isolates each coefficient term and shows whether rounding or truncation is used. A small-amplitude impulse separates rounding from truncation. A constant step exercises the accumulated state. A full-scale input that repeats every four samples sits near the filter's resonance, drives the state into the clamps, and so separates saturation from wraparound. A random sequence covers mixed signs. Separate handshake variants drop the request early, or drop and raise it again during the computation, to show that the ready flag timing holds and that the extra rise is ignored.

// File: rtl/biq_pkg.sv
package biq_pkg;

  localparam int SW   = 16;  // sample width
  localparam int CW   = 16;  // coefficient width (Q1.14)
  localparam int FRAC = 14;  // fraction bits of coefficients
  localparam int ACCW = 40;  // width used before clamping

  typedef logic signed [SW-1:0] smp_t;
  typedef logic signed [CW-1:0] coef_t;

  // multiplier operations: destination register implied by the code
  typedef enum logic [2:0] {
    MO_NONE, MO_U1, MO_U2, MO_V0, MO_V1, MO_V2
  } mop_e;

  // adder operations
  typedef enum logic [2:0] {
    AO_NONE, AO_U3, AO_W0, AO_V3, AO_Y
  } aop_e;

  typedef enum logic [1:0] {
    CS_IDLE, CS_RUN, CS_HOLD
  } cst_e;

  localparam logic signed [ACCW-1:0] SAT_HI = ACCW'(2**(SW-1) - 1);
  localparam logic signed [ACCW-1:0] SAT_LO = -SAT_HI - 1;

  // number of control steps for a given multiplier count
  function automatic int n_steps(input int n_mul);
    return (n_mul >= 2) ? 5 : 6;
  endfunction

  function automatic smp_t sat_w(input logic signed [ACCW-1:0] v);
    smp_t r;
    if (v > SAT_HI)      r = smp_t'(SAT_HI[SW-1:0]);
    else if (v < SAT_LO) r = smp_t'(SAT_LO[SW-1:0]);
    else                 r = smp_t'(v[SW-1:0]);
    return r;
  endfunction

endpackage

// File: rtl/biq_mul.sv
// Shared multiplier: Q1.14 coefficient times sample, rounded, clamped.
module biq_mul
  import biq_pkg::*;
(
  input  coef_t coef,
  input  smp_t  opnd,
  output smp_t  res
);
  localparam int PW   = SW + CW + 1;
  localparam int HALF = 1 << (FRAC - 1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] shf;

  always_comb begin
    prod = PW'(coef) * PW'(opnd);
    rnd  = prod + PW'(HALF);
    shf  = rnd >>> FRAC;
    res  = sat_w(ACCW'(shf));
  end
endmodule

// File: rtl/biq_add.sv
// Shared adder with clamping.
module biq_add
  import biq_pkg::*;
(
  input  smp_t a,
  input  smp_t b,
  output smp_t res
);
  logic signed [ACCW-1:0] sum;

  always_comb begin
    sum = ACCW'(a) + ACCW'(b);
    res = sat_w(sum);
  end
endmodule

// File: rtl/biq_sched.sv
// Step-to-unit binding table. One entry per control step; each unit
// carries at most one operation per step.
module biq_sched
  import biq_pkg::*;
#(
  parameter int NUM_MUL = 1,
  parameter int STW     = 3
) (
  input  logic           run,
  input  logic [STW-1:0] step,
  output mop_e           mop [NUM_MUL],
  output aop_e           aop
);
  if (NUM_MUL == 1) begin : g_one
    always_comb begin
      mop[0] = MO_NONE;
      aop    = AO_NONE;
      if (run) begin
        case (step)
          STW'(0): mop[0] = MO_U1;
          STW'(1): mop[0] = MO_U2;
          STW'(2): begin mop[0] = MO_V1; aop = AO_U3; end
          STW'(3): begin mop[0] = MO_V2; aop = AO_W0; end
          STW'(4): begin mop[0] = MO_V0; aop = AO_V3; end
          STW'(5): aop = AO_Y;
          default: ;
        endcase
      end
    end
  end else begin : g_two
    always_comb begin
      mop[0] = MO_NONE;
      mop[1] = MO_NONE;
      aop    = AO_NONE;
      if (run) begin
        case (step)
          STW'(0): begin mop[0] = MO_U1; mop[1] = MO_U2; end
          STW'(1): begin mop[0] = MO_V1; mop[1] = MO_V2; aop = AO_U3; end
          STW'(2): aop = AO_W0;
          STW'(3): begin mop[0] = MO_V0; aop = AO_V3; end
          STW'(4): aop = AO_Y;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/biq_ctrl.sv
// Handshake and step sequencer.
module biq_ctrl
  import biq_pkg::*;
#(
  parameter int NSTEP = 6,
  parameter int STW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_req,
  output logic           start,
  output logic           run,
  output logic [STW-1:0] step,
  output logic           out_rdy
);
  localparam logic [STW-1:0] LAST = STW'(NSTEP - 1);

  cst_e           st_q, st_nx;
  logic [STW-1:0] step_q, step_nx;
  logic           req_q;

  always_comb begin
    st_nx   = st_q;
    step_nx = step_q;
    start   = 1'b0;
    case (st_q)
      CS_IDLE: begin
        if (in_req && !req_q) begin
          start   = 1'b1;
          st_nx   = CS_RUN;
          step_nx = '0;
        end
      end
      CS_RUN: begin
        if (step_q == LAST) st_nx = CS_HOLD;
        else                step_nx = step_q + STW'(1);
      end
      CS_HOLD: begin
        if (!in_req) st_nx = CS_IDLE;
      end
      default: st_nx = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      step_q <= '0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_nx;
      step_q <= step_nx;
      req_q  <= in_req;
    end
  end

  assign run     = (st_q == CS_RUN);
  assign step    = step_q;
  assign out_rdy = (st_q == CS_HOLD);
endmodule

// File: rtl/biquad_sched.sv
// Scheduled second-order recursive filter on shared arithmetic units.
module biquad_sched
  import biq_pkg::*;
#(
  parameter int    NUM_MUL = 1,
  parameter coef_t KA0     = 16'sd4846,
  parameter coef_t KA1     = 16'sd9627,
  parameter coef_t KA2     = 16'sd4846,
  parameter coef_t KB1     = -16'sd3503,
  parameter coef_t KB2     = -16'sd7402
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_req,
  input  logic [15:0] in_sample,
  output logic        out_rdy,
  output logic [15:0] out_sample
);
  localparam int NM    = (NUM_MUL >= 2) ? 2 : 1;
  localparam int NSTEP = n_steps(NM);
  localparam int STW   = $clog2(NSTEP);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // control
  logic           start, run;
  logic [STW-1:0] step;
  mop_e           mop [NM];
  aop_e           aop;

  biq_ctrl #(.NSTEP(NSTEP), .STW(STW)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .in_req  (in_req),
    .start   (start),
    .run     (run),
    .step    (step),
    .out_rdy (out_rdy)
  );

  biq_sched #(.NUM_MUL(NM), .STW(STW)) i_sched (
    .run  (run),
    .step (step),
    .mop  (mop),
    .aop  (aop)
  );

  // datapath registers
  smp_t w0_q, w1_q, w2_q, x_q;
  smp_t u1_q, u2_q, u3_q, v0_q, v1_q, v2_q, v3_q, y_q;
  smp_t w0_nx, w1_nx, w2_nx, x_nx;
  smp_t u1_nx, u2_nx, u3_nx, v0_nx, v1_nx, v2_nx, v3_nx, y_nx;
  logic dp_en;

  // multiplier pool
  smp_t m_res [NM];

  for (genvar g = 0; g < NM; g++) begin : g_mul
    coef_t cf;
    smp_t  op;
    always_comb begin
      case (mop[g])
        MO_U1:   begin cf = KB1; op = w1_q; end
        MO_U2:   begin cf = KB2; op = w2_q; end
        MO_V0:   begin cf = KA0; op = w0_q; end
        MO_V1:   begin cf = KA1; op = w1_q; end
        MO_V2:   begin cf = KA2; op = w2_q; end
        default: begin cf = '0;  op = '0;   end
      endcase
    end
    biq_mul i_mul (.coef(cf), .opnd(op), .res(m_res[g]));
  end

  // single adder
  smp_t a_in0, a_in1, a_res;

  always_comb begin
    case (aop)
      AO_U3:   begin a_in0 = u1_q; a_in1 = u2_q; end
      AO_W0:   begin a_in0 = x_q;  a_in1 = u3_q; end
      AO_V3:   begin a_in0 = v1_q; a_in1 = v2_q; end
      AO_Y:    begin a_in0 = v0_q; a_in1 = v3_q; end
      default: begin a_in0 = '0;   a_in1 = '0;   end
    endcase
  end

  biq_add i_add (.a(a_in0), .b(a_in1), .res(a_res));

  // write-back
  assign dp_en = start | run;

  always_comb begin
    w0_nx = w0_q; w1_nx = w1_q; w2_nx = w2_q; x_nx = x_q;
    u1_nx = u1_q; u2_nx = u2_q; u3_nx = u3_q;
    v0_nx = v0_q; v1_nx = v1_q; v2_nx = v2_q; v3_nx = v3_q;
    y_nx  = y_q;
    if (start) begin
      w2_nx = w1_q;
      w1_nx = w0_q;
      x_nx  = smp_t'(in_sample);
    end
    for (int i = 0; i < NM; i++) begin
      case (mop[i])
        MO_U1:   u1_nx = m_res[i];
        MO_U2:   u2_nx = m_res[i];
        MO_V0:   v0_nx = m_res[i];
        MO_V1:   v1_nx = m_res[i];
        MO_V2:   v2_nx = m_res[i];
        default: ;
      endcase
    end
    case (aop)
      AO_U3:   u3_nx = a_res;
      AO_W0:   w0_nx = a_res;
      AO_V3:   v3_nx = a_res;
      AO_Y:    y_nx  = a_res;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      w0_q <= '0; w1_q <= '0; w2_q <= '0; x_q <= '0;
      u1_q <= '0; u2_q <= '0; u3_q <= '0;
      v0_q <= '0; v1_q <= '0; v2_q <= '0; v3_q <= '0;
      y_q  <= '0;
    end else if (dp_en) begin
      w0_q <= w0_nx; w1_q <= w1_nx; w2_q <= w2_nx; x_q <= x_nx;
      u1_q <= u1_nx; u2_q <= u2_nx; u3_q <= u3_nx;
      v0_q <= v0_nx; v1_q <= v1_nx; v2_q <= v2_nx; v3_q <= v3_nx;
      y_q  <= y_nx;
    end
  end

  assign out_sample = y_q;
endmodule

// File: rtl/biq_chk.sv
// Port-level protocol checker, bound to the filter.
module biq_chk
  import biq_pkg::*;
#(
  parameter int N_MUL = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_req,
  input logic        out_rdy,
  input logic [15:0] out_sample
);
  localparam int LAT = n_steps(N_MUL) + 1;

  logic       in_q, busy;
  logic [7:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      in_q <= in_req;
      if (!busy && in_req && !in_q) begin
        busy <= 1'b1;
        cnt  <= 8'd1;
      end else if (busy) begin
        if (out_rdy && !in_req) busy <= 1'b0;
        if (cnt != 8'hFF) cnt <= cnt + 8'd1;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_rdy && out_sample == 16'd0));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> (cnt == 8'(LAT)));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> busy);

  // R6
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy && in_req) |=> out_rdy);

  // R6
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy && !in_req) |=> !out_rdy);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(out_rdy) |-> $stable(out_sample));
endmodule

bind biquad_sched biq_chk #(.N_MUL(NUM_MUL)) i_biq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_req     (in_req),
  .out_rdy    (out_rdy),
  .out_sample (out_sample)
);

// File: tb/test_biquad_sched.sv
module test_biquad_sched;

  logic        clk;
  logic        rst_n;
  logic        in_req;
  logic [15:0] in_sample;
  logic        rdy1, rdy2;
  logic [15:0] y1, y2;

  int checks = 0;
  int errors = 0;

  // model state
  logic signed [15:0] m_w0, m_w1, m_w2;

  biquad_sched #(.NUM_MUL(1)) i_biquad_sched (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_sample(in_sample),
    .out_rdy(rdy1), .out_sample(y1)
  );

  biquad_sched #(.NUM_MUL(2)) i_biquad_sched_m2 (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_sample(in_sample),
    .out_rdy(rdy2), .out_sample(y2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] sat(input longint v);
    if (v > 32767)  return 16'sd32767;
    if (v < -32768) return -16'sd32768;
    return 16'(v);
  endfunction

  function automatic logic signed [15:0] qmul(input longint c, input logic signed [15:0] s);
    longint p;
    p = c * longint'(s) + 8192;
    return sat(p >>> 14);
  endfunction

  // R2 R3 R4: reference arithmetic
  function automatic logic signed [15:0] model_step(input logic signed [15:0] x);
    logic signed [15:0] u1, u2, u3, v0, v1, v2, v3;
    m_w2 = m_w1;
    m_w1 = m_w0;
    u1 = qmul(-3503, m_w1);
    u2 = qmul(-7402, m_w2);
    u3 = sat(longint'(u1) + longint'(u2));
    m_w0 = sat(longint'(x) + longint'(u3));
    v0 = qmul(4846, m_w0);
    v1 = qmul(9627, m_w1);
    v2 = qmul(4846, m_w2);
    v3 = sat(longint'(v1) + longint'(v2));
    return sat(longint'(v0) + longint'(v3));
  endfunction

  task automatic do_reset();
    in_req = 1'b0;
    in_sample = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1: outputs cleared during reset
    chk_eq("R1 rdy m1", rdy1, 0);
    chk_eq("R1 rdy m2", rdy2, 0);
    chk_eq("R1 out m1", longint'($signed(y1)), 0);
    chk_eq("R1 out m2", longint'($signed(y2)), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_w0 = '0; m_w1 = '0; m_w2 = '0;
  endtask

  // mode 0: normal, 1: request dropped early, 2: dropped and raised again mid-run
  task automatic xfer(input logic signed [15:0] x, input int mode, output logic signed [15:0] ye);
    int k1 = 0, k2 = 0, h1 = 0, h2 = 0;
    ye = model_step(x);
    @(negedge clk);
    in_sample = x;
    in_req = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (rdy1) begin h1++; if (k1 == 0) k1 = k; end
      if (rdy2) begin h2++; if (k2 == 0) k2 = k; end
      if (mode >= 1 && k == 2) in_req = 1'b0;
      if (mode == 2 && k == 3) in_req = 1'b1;
    end
    chk_eq("R5 latency m1", k1, 7);
    chk_eq("R5 latency m2", k2, 6);
    chk_eq("R6 high cycles m1", h1, (mode == 1) ? 1 : 6);
    chk_eq("R6 high cycles m2", h2, (mode == 1) ? 1 : 7);
    chk_eq("R2 value m1", longint'($signed(y1)), longint'(ye));
    chk_eq("R9 value m2", longint'($signed(y2)), longint'(ye));
    in_req = 1'b0;
    @(negedge clk);
    chk_eq("R6 drop m1", rdy1, 0);
    chk_eq("R6 drop m2", rdy2, 0);
    chk_eq("R8 hold m1", longint'($signed(y1)), longint'(ye));
    chk_eq("R8 hold m2", longint'($signed(y2)), longint'(ye));
  endtask

  task automatic test_impulse();
    logic signed [15:0] ye;
    do_reset();
    xfer(16'sd16384, 0, ye);
    chk_eq("R3 ka0 term", longint'($signed(y1)), 4846);
    for (int i = 0; i < 6; i++) xfer(16'sd0, 0, ye);
    do_reset();
    xfer(16'sd2, 0, ye);
    chk_eq("R3 rounding", longint'($signed(y1)), 1);
  endtask

  task automatic test_step();
    logic signed [15:0] ye;
    do_reset();
    for (int i = 0; i < 12; i++) xfer(16'sd8000, 0, ye);
  endtask

  task automatic test_sat();
    logic signed [15:0] ye;
    logic signed [15:0] pat [4];
    pat[0] = 16'sd32767; pat[1] = 16'sd0; pat[2] = -16'sd32768; pat[3] = 16'sd0;
    do_reset();
    // R4: near-resonant full-scale drive pushes the state into the clamps
    for (int i = 0; i < 32; i++) xfer(pat[i % 4], 0, ye);
  endtask

  task automatic test_random();
    logic signed [15:0] ye;
    do_reset();
    for (int i = 0; i < 40; i++) xfer(16'($urandom), 0, ye);
  endtask

  task automatic test_handshake();
    logic signed [15:0] ye;
    do_reset();
    xfer(16'sd5000, 1, ye);   // R6: early drop gives a one-cycle flag
    xfer(-16'sd7000, 2, ye);  // R7: extra rise during computation
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk_eq("R7 no second result m1", rdy1, 0);
      chk_eq("R7 no second result m2", rdy2, 0);
    end
    chk_eq("R7 output kept", longint'($signed(y1)), longint'(ye));
    xfer(16'sd1234, 0, ye);   // R7: state advanced only once
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_req = 1'b0;
    in_sample = '0;
    test_impulse();
    test_step();
    test_sat();
    test_random();
    test_handshake();
    do_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule